// File: doc/BRIEF.md
# Single-Cycle 32-bit Load-Store Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It fetches from a word-addressed instruction memory inside the block and uses a data memory that is also inside the block. The design has no pipeline, so no hazard logic is needed. A 32-entry register file feeds an ALU that takes two registers or a register and an immediate. A next-PC selector chooses among four sources: sequential flow, PC-relative conditional branches, region-relative jumps, and jumps through a register.

Both memories are filled through a load port while reset is held low. When reset is released, execution starts at address 0. A combinational debug port returns the value of any register, so a harness can inspect the architectural results.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, the PC is 0 and every register reads 0. While rst_n is low and load_en is high, each rising clock edge writes load_data into the word at load_addr. The target is the data memory when load_sel is 1 and the instruction memory when load_sel is 0.
- R2: Register 0 always reads 0, and any write to it is discarded. The PC always stays a multiple of 4.
- R3: Register-format words have opcode 0 (bits 31:26). They use rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11. The result goes to rd, and the operation depends on funct (bits 5:0): 32 is add, 34 is subtract (rs-rt), 36 is AND, 37 is OR, 39 is NOR, and 42 writes 1 if rs is less than rt as signed values and 0 otherwise.
- R4: funct 0 shifts rt left, and funct 2 shifts rt right logically. The shift amount comes from bits 10:6, and the result goes to rd.
- R5: Opcode 8 writes rs plus the sign-extended imm (bits 15:0) to rt. Opcode 10 writes 1 to rt if rs is less than the sign-extended imm as signed values, and 0 otherwise.
- R6: Opcode 12 (AND) and opcode 13 (OR) combine rs with the zero-extended imm and write rt. Opcode 15 writes imm to the upper half of rt and clears the lower half.
- R7: Opcode 35 loads a word and opcode 43 stores rt. The byte address is rs plus the sign-extended imm, and the word index comes from address bits above bit 1. A stored word can be read back by a later load.
- R8: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 plus the sign-extended imm shifted left by 2. A branch that is not taken goes to PC+4.
- R9: Opcode 2 jumps to {(PC+4)[31:28], bits 25:0, 2'b00}.
- R10: Opcode 3 jumps in the same way as opcode 2 and writes PC+4 to register 31. Register-format funct 8 loads the PC from rs.
- R11: Every instruction that is not a jump or a taken branch advances the PC by 4. This includes unknown opcodes and unknown funct codes, which change no register and no memory word.
- R12: dbg_data always shows the register selected by dbg_addr, and pc_out shows the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the load port is active only while it is low |
| load_en | input | 1 | Memory load strobe |
| load_sel | input | 1 | 1 selects the data memory, 0 the instruction memory |
| load_addr | input | AW | Word index to load |
| load_data | input | 32 | Word to load |
| dbg_addr | input | 5 | Register to observe |
| dbg_data | output | 32 | Value of the observed register |
| pc_out | output | 32 | Current program counter |

## Verification
The bench uses the default MEM_WORDS of 64, which fits both the directed control-flow program and the randomized data-path program. With this depth, forward branches, backward jumps through the link register, base-plus-negative-offset loads and store-then-load round trips can all be reached. The upper four PC bits stay zero throughout. For that reason, the region-keeping part of the jump target is covered by the jump assertion only as a zero-preserving case.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          load_sel,
  input  logic [AW-1:0] load_addr,
  input  logic [31:0]   load_data,
  input  logic [4:0]    dbg_addr,
  output logic [31:0]   dbg_data,
  output logic [31:0]   pc_out
);
  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr, pc4;

  assign instr = imem[pc[AW+1:2]];
  assign pc4   = pc + 32'd4;

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, sh;
  logic [15:0] imm;
  logic [31:0] sx, zx, rs_v, rt_v, sum, br_tgt, j_tgt;

  assign op   = instr[31:26];
  assign rs   = instr[25:21];
  assign rt   = instr[20:16];
  assign rd   = instr[15:11];
  assign sh   = instr[10:6];
  assign fn   = instr[5:0];
  assign imm  = instr[15:0];
  assign sx   = {{16{imm[15]}}, imm};
  assign zx   = {16'd0, imm};
  assign rs_v = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_v = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign sum  = rs_v + sx;
  assign br_tgt = pc4 + {sx[29:0], 2'b00};
  assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

  logic        wb_en, dm_we;
  logic [4:0]  wb_sel;
  logic [31:0] wb_data, npc;

  always_comb begin
    wb_en   = 1'b0;
    wb_sel  = rt;
    wb_data = 32'd0;
    npc     = pc4;
    dm_we   = 1'b0;
    case (op)
      6'd0: begin
        wb_sel = rd;
        wb_en  = 1'b1;
        case (fn)
          6'd32: wb_data = rs_v + rt_v;
          6'd34: wb_data = rs_v - rt_v;
          6'd36: wb_data = rs_v & rt_v;
          6'd37: wb_data = rs_v | rt_v;
          6'd39: wb_data = ~(rs_v | rt_v);
          6'd42: wb_data = {31'd0, $signed(rs_v) < $signed(rt_v)};
          6'd0:  wb_data = rt_v << sh;
          6'd2:  wb_data = rt_v >> sh;
          6'd8: begin
            wb_en = 1'b0;
            npc   = rs_v;
          end
          default: wb_en = 1'b0;
        endcase
      end
      6'd8:  begin wb_en = 1'b1; wb_data = sum; end
      6'd10: begin wb_en = 1'b1; wb_data = {31'd0, $signed(rs_v) < $signed(sx)}; end
      6'd12: begin wb_en = 1'b1; wb_data = rs_v & zx; end
      6'd13: begin wb_en = 1'b1; wb_data = rs_v | zx; end
      6'd15: begin wb_en = 1'b1; wb_data = {imm, 16'd0}; end
      6'd35: begin wb_en = 1'b1; wb_data = dmem[sum[AW+1:2]]; end
      6'd43: dm_we = 1'b1;
      6'd4:  if (rs_v == rt_v) npc = br_tgt;
      6'd5:  if (rs_v != rt_v) npc = br_tgt;
      6'd2:  npc = j_tgt;
      6'd3: begin
        npc     = j_tgt;
        wb_en   = 1'b1;
        wb_sel  = 5'd31;
        wb_data = pc4;
      end
      default: ;
    endcase
  end

  logic rf_we;
  assign rf_we = wb_en && (wb_sel != 5'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= 32'd0;
    else        pc <= {npc[31:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rf_we) begin
      rf[wb_sel] <= wb_data;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      if (load_en && !load_sel) imem[load_addr] <= load_data;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      if (load_en && load_sel) dmem[load_addr] <= load_data;
    end else if (dm_we) begin
      dmem[sum[AW+1:2]] <= rt_v;
    end

  assign dbg_data = (dbg_addr == 5'd0) ? 32'd0 : rf[dbg_addr];
  assign pc_out   = pc;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic [4:0]  wb_sel,
  input logic [31:0] wb_data,
  input logic [4:0]  dbg_addr,
  input logic [31:0] dbg_data
);
  logic [5:0]  op;
  logic [31:0] p4;
  logic        ctl;
  assign op  = instr[31:26];
  assign p4  = pc + 32'd4;
  assign ctl = (op == 6'd0) || (op == 6'd2) || (op == 6'd3) || (op == 6'd4) || (op == 6'd5);

  a_r1_pc_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == 32'd0);
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
  a_r12_zero_reg_visible: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_addr == 5'd0 |-> dbg_data == 32'd0);
  a_r11_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl |=> pc == $past(p4));
  a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    op == 6'd2 |=> pc == {$past(p4[31:28]), $past(instr[25:0]), 2'b00});
  a_r10_link_write: assert property (@(posedge clk) disable iff (!rst_n)
    op == 6'd3 |-> rf_we && wb_sel == 5'd31 && wb_data == p4);
endmodule

bind sc_core sc_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pc(pc), .instr(instr), .rf_we(rf_we),
  .wb_sel(wb_sel), .wb_data(wb_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0, load_en = 1'b0, load_sel = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0] load_data = '0, dbg_data, pc_out;
  logic [4:0] dbg_addr = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sc_core #(.MEM_WORDS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .pc_out(pc_out)
  );

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int a, input int f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'(a), 6'(f)};
  endfunction
  function automatic logic [31:0] enc_i(input int o, input int s, input int t, input logic [15:0] im);
    return {6'(o), 5'(s), 5'(t), im};
  endfunction
  function automatic logic [31:0] enc_j(input int o, input int tg);
    return {6'(o), 26'(tg)};
  endfunction
  function automatic logic [31:0] sxt(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
    dbg_addr = 5'(r);
    #1;
    check(req, dbg_data, exp);
  endtask

  task automatic load(input logic sel, input int a, input logic [31:0] d);
    @(negedge clk);
    load_en = 1'b1; load_sel = sel; load_addr = AW'(a); load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b, r3;
    logic [15:0] im;
    int sa;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check("R1 pc in reset", pc_out, 32'd0);
    chk_reg("R1 reg clear", 7, 32'd0);

    // directed control flow program
    load(0, 0,  enc_i(8, 0, 1, 16'd5));
    load(0, 1,  enc_i(8, 0, 2, 16'd5));
    load(0, 2,  enc_i(4, 1, 2, 16'd1));
    load(0, 3,  enc_i(8, 0, 3, 16'd1));
    load(0, 4,  enc_i(5, 1, 2, 16'd1));
    load(0, 5,  enc_i(8, 0, 4, 16'd7));
    load(0, 6,  enc_j(3, 10));
    load(0, 7,  enc_i(8, 0, 5, 16'd9));
    load(0, 8,  enc_i(8, 0, 0, 16'd3));
    load(0, 9,  enc_j(2, 9));
    load(0, 10, 32'hFC00_0000 | enc_i(0, 1, 7, 16'h1234));
    load(0, 11, enc_r(1, 2, 8, 0, 63));
    load(0, 12, enc_i(8, 0, 6, 16'hFFFF));
    load(0, 13, enc_r(31, 0, 0, 0, 8));
    run(1);
    check("R11 first step pc", pc_out, 32'd4);
    run(29);
    chk_reg("R8 taken branch skips", 3, 32'd0);
    chk_reg("R8 untaken branch falls through", 4, 32'd7);
    chk_reg("R10 link reg", 31, 32'd28);
    chk_reg("R10 return via register", 5, 32'd9);
    chk_reg("R2 write to r0 dropped", 0, 32'd0);
    chk_reg("R11 unknown opcode no write", 7, 32'd0);
    chk_reg("R11 unknown funct no write", 8, 32'd0);
    chk_reg("R5 negative immediate", 6, 32'hFFFF_FFFF);
    check("R9 halt jump pc", pc_out, 32'd36);
    hold_reset();
    #1 check("R1 pc back to zero", pc_out, 32'd0);
    chk_reg("R1 regs cleared", 31, 32'd0);

    load(0, 0,  enc_i(35, 0, 1, 16'd0));
    load(0, 1,  enc_i(35, 0, 2, 16'd4));
    load(0, 2,  enc_r(1, 2, 3, 0, 32));
    load(0, 3,  enc_r(1, 2, 4, 0, 34));
    load(0, 4,  enc_r(1, 2, 5, 0, 36));
    load(0, 5,  enc_r(1, 2, 6, 0, 37));
    load(0, 6,  enc_r(1, 2, 7, 0, 39));
    load(0, 7,  enc_r(1, 2, 8, 0, 42));
    load(0, 15, enc_i(43, 0, 3, 16'd8));
    load(0, 16, enc_i(8, 0, 20, 16'd4));
    load(0, 17, enc_i(35, 20, 21, 16'd4));
    load(0, 18, enc_i(35, 20, 22, 16'hFFFC));
    load(0, 19, enc_j(2, 19));

    for (int it = 0; it < 24; it++) begin
      if (it == 0) begin a = 32'h7FFF_FFFF; b = 32'h8000_0000; im = 16'h8000; sa = 31; end
      else if (it == 1) begin a = 32'h8000_0001; b = 32'h0000_0001; im = 16'h7FFF; sa = 0; end
      else begin a = $urandom; b = $urandom; im = 16'($urandom); sa = int'($urandom % 32); end
      if (it > 0) hold_reset();
      load(1, 0, a);
      load(1, 1, b);
      load(0, 8,  enc_r(0, 1, 9, sa, 0));
      load(0, 9,  enc_r(0, 1, 10, sa, 2));
      load(0, 10, enc_i(8, 1, 11, im));
      load(0, 11, enc_i(10, 1, 12, im));
      load(0, 12, enc_i(12, 1, 13, im));
      load(0, 13, enc_i(13, 1, 14, im));
      load(0, 14, enc_i(15, 0, 15, im));
      run(26);
      r3 = a + b;
      chk_reg("R7 load word", 1, a);
      chk_reg("R3 add", 3, r3);
      chk_reg("R3 sub", 4, a - b);
      chk_reg("R3 and", 5, a & b);
      chk_reg("R3 or", 6, a | b);
      chk_reg("R3 nor", 7, ~(a | b));
      chk_reg("R3 slt", 8, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
      chk_reg("R4 shift left", 9, a << sa);
      chk_reg("R4 shift right", 10, a >> sa);
      chk_reg("R5 addi", 11, a + sxt(im));
      chk_reg("R5 slti", 12, ($signed(a) < $signed(sxt(im))) ? 32'd1 : 32'd0);
      chk_reg("R6 andi", 13, a & {16'd0, im});
      chk_reg("R6 ori", 14, a | {16'd0, im});
      chk_reg("R6 upper immediate", 15, {im, 16'd0});
      chk_reg("R7 store then load", 21, r3);
      chk_reg("R7 negative offset", 22, a);
      check("R12 pc observed", pc_out, 32'd76);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule